// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Command Unit

This block wakes on a channel-attention strobe and carries out a list of commands that a host has left in shared memory. It first reads a fixed control block, which holds a start flag and a pointer to the command list. It then steps through linked command blocks. A command with the transmit opcode points to a chain of buffer descriptors. For each descriptor the unit reads the buffer's words from memory in a burst and pushes them into a transmit FIFO. When the last command has run, the unit writes a status word back into the control block and returns to idle.

The unit masters one word-wide memory port that uses a request/acknowledge handshake. Read data is valid in the cycle that acknowledge is high, and it is passed straight to the FIFO write port. A full flag from the FIFO pauses the burst without losing any words. An attention strobe that arrives while a list is being processed is remembered, and a new pass starts once the current pass has finished.

Top module: `txdma_engine`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_req` and `fifo_wr` are low, and no request or push happens while `busy` is low.
- R2: A pass starts on the falling edge of `attn`, so `busy` is high in the third clock after the cycle in which `attn` goes low. While `attn` stays high and no edge has been seen, the unit stays idle.
- R3: The control block sits at `SCB_BASE`. Bit 0 of word 0 is the start flag and word 1 is the command-list pointer. If the start flag is 0, the unit reads only word 0 and returns to idle without writing anything.
- R4: A command block has three words. Word 0 holds an end-of-list flag in bit 15 and an opcode in bits 2:0, where 1 means transmit and any other value is a no-op. Word 1 is the link to the next command block. Word 2 is the first descriptor pointer, which is read only for transmit.
- R5: A descriptor has three words. Word 0 holds a word count in bits 14:0 and an end-of-chain flag in bit 15. Word 1 is the next-descriptor pointer. Word 2 is the buffer address. Buffer words are pushed to the FIFO in ascending address order, and descriptors are taken in chain order.
- R6: A descriptor with a count of 0 pushes nothing, and the walk moves on to the next descriptor.
- R7: No push happens while `fifo_full` is high. Across stalls, every buffer word is pushed exactly once.
- R8: A memory request that has not been acknowledged stays asserted, with stable address and direction, in the next cycle. The only exception is a burst read that is withdrawn because `fifo_full` is high.
- R9: When a command with end-of-list set completes, the unit writes `0x8000 | words_pushed_this_pass` to word 2 of the control block and is idle in the next cycle.
- R10: An attention falling edge that occurs while the unit is busy is held, and it starts one further pass after the current pass ends.
- R11: The status write is the only memory write the unit ever makes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| attn | input | 1 | Channel attention, active high, acted on at its falling edge |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable (1 = write) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data (status word) |
| mem_ack | input | 1 | Memory acknowledge; completes the request this cycle |
| mem_rdata | input | DW | Memory read data, valid when `mem_ack` is high |
| fifo_wr | output | 1 | Push a word into the transmit FIFO |
| fifo_data | output | DW | Word pushed into the FIFO |
| fifo_full | input | 1 | FIFO cannot accept a word |
| busy | output | 1 | A pass is in progress |

## Verification
The bench builds the unit with AW = 8 and SCB_BASE = 0x10, with DW left at 16. The whole memory image therefore fits in a 256-word array that the bench reads directly. This keeps command lists, descriptor chains and buffers small enough to place by hand, so no-op commands, zero-count descriptors and chains of several descriptors can all be tried. Periodic acknowledge stalls and FIFO-full windows are applied over the same image, so withdrawn burst requests and held requests both occur inside a single pass.

// File: rtl/txdma_pkg.sv
// Package: shared state encoding and field positions for the transmit DMA unit.
// Assumes word-wide memory with 16-bit-or-wider words; flag bits sit at the word MSB.
package txdma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SCB_CMD,
        S_SCB_PTR,
        S_CB_HDR,
        S_CB_LINK,
        S_CB_TBD,
        S_TD_CNT,
        S_TD_NEXT,
        S_TD_BUF,
        S_BURST,
        S_STATUS
    } tx_state_t;

    localparam int          OPW      = 3;     // opcode field width in a command header
    localparam logic [2:0]  OP_XMIT  = 3'd1;  // transmit opcode
    localparam int          START_BIT = 0;    // start flag in control-block word 0

endpackage

// File: rtl/txdma_attn_latch.sv
// Module: remembers a falling edge on the attention input until the sequencer takes it.
// Assumes attn is already synchronous to clk and held high for at least one cycle.
module txdma_attn_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic attn_i,
    input  logic take_i,
    output logic pend_o
);

    logic attn_q;

    // Delay attn by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) attn_q <= 1'b0;
        else        attn_q <= attn_i;
    end

    // Set on a falling edge, clear when taken; a new edge wins over a take.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= (attn_q & ~attn_i) | (pend_o & ~take_i);
    end

endmodule

// File: rtl/txdma_addr_gen.sv
// Module: picks the memory address for the current sequencer state.
// Assumes each structure is read as consecutive words from its base pointer.
module txdma_addr_gen
    import txdma_pkg::*;
#(
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  SCB_BASE = '0
) (
    input  tx_state_t         state_i,
    input  logic [AW-1:0]     cmd_ptr_i,
    input  logic [AW-1:0]     td_ptr_i,
    input  logic [AW-1:0]     buf_ptr_i,
    output logic [AW-1:0]     addr_o
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    // Address multiplexer over the structure being walked.
    always_comb begin
        case (state_i)
            S_SCB_CMD: addr_o = SCB_BASE;
            S_SCB_PTR: addr_o = SCB_BASE + ONE;
            S_CB_HDR:  addr_o = cmd_ptr_i;
            S_CB_LINK: addr_o = cmd_ptr_i + ONE;
            S_CB_TBD:  addr_o = cmd_ptr_i + TWO;
            S_TD_CNT:  addr_o = td_ptr_i;
            S_TD_NEXT: addr_o = td_ptr_i + ONE;
            S_TD_BUF:  addr_o = td_ptr_i + TWO;
            S_BURST:   addr_o = buf_ptr_i;
            S_STATUS:  addr_o = SCB_BASE + TWO;
            default:   addr_o = '0;
        endcase
    end

endmodule

// File: rtl/txdma_seq.sv
// Module: command/descriptor sequencer; walks the control block, command list and
// descriptor chains, bursts buffer words to the FIFO and writes the final status.
// Assumes AW <= DW so pointers fit a memory word; read data is valid with mem_ack.
module txdma_seq
    import txdma_pkg::*;
#(
    parameter int             AW       = 16,
    parameter int             DW       = 16,
    parameter logic [AW-1:0]  SCB_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              take_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_data,
    input  logic              fifo_full,
    output logic              busy
);

    localparam int CW = DW - 1;               // count / status field width
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    tx_state_t     state;
    logic [AW-1:0] cmd_ptr, cb_link, td_ptr, td_next, buf_ptr;
    logic [CW-1:0] remain, moved;
    logic          last_cmd, is_xmit, last_td;
    logic          hit;
    tx_state_t     after_cmd, after_buf;

    // Request/handshake outputs decoded from state; bursts pause on a full FIFO.
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = busy && !(state == S_BURST && fifo_full);
        mem_we    = (state == S_STATUS);
        mem_wdata = {1'b1, moved};
        hit       = mem_req && mem_ack;
        fifo_wr   = (state == S_BURST) && hit;
        fifo_data = mem_rdata;
        take_o    = (state == S_IDLE) && start_i;
        after_cmd = last_cmd ? S_STATUS : S_CB_HDR;
        after_buf = last_td ? after_cmd : S_TD_CNT;
    end

    txdma_addr_gen #(.AW(AW), .SCB_BASE(SCB_BASE)) u_addr (
        .state_i   (state),
        .cmd_ptr_i (cmd_ptr),
        .td_ptr_i  (td_ptr),
        .buf_ptr_i (buf_ptr),
        .addr_o    (mem_addr)
    );

    // Main walk: one state per word fetched, advancing on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cmd_ptr  <= '0;
            cb_link  <= '0;
            td_ptr   <= '0;
            td_next  <= '0;
            buf_ptr  <= '0;
            remain   <= '0;
            moved    <= '0;
            last_cmd <= 1'b0;
            is_xmit  <= 1'b0;
            last_td  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start_i) state <= S_SCB_CMD;
                S_SCB_CMD: if (hit) state <= mem_rdata[START_BIT] ? S_SCB_PTR : S_IDLE;
                S_SCB_PTR: if (hit) begin
                    cmd_ptr <= mem_rdata[AW-1:0];
                    moved   <= '0;
                    state   <= S_CB_HDR;
                end
                S_CB_HDR: if (hit) begin
                    last_cmd <= mem_rdata[DW-1];
                    is_xmit  <= (mem_rdata[OPW-1:0] == OP_XMIT);
                    state    <= S_CB_LINK;
                end
                S_CB_LINK: if (hit) begin
                    cb_link <= mem_rdata[AW-1:0];
                    if (is_xmit) begin
                        state <= S_CB_TBD;
                    end else begin
                        if (!last_cmd) cmd_ptr <= mem_rdata[AW-1:0];
                        state <= after_cmd;
                    end
                end
                S_CB_TBD: if (hit) begin
                    td_ptr <= mem_rdata[AW-1:0];
                    state  <= S_TD_CNT;
                end
                S_TD_CNT: if (hit) begin
                    remain  <= mem_rdata[CW-1:0];
                    last_td <= mem_rdata[DW-1];
                    state   <= S_TD_NEXT;
                end
                S_TD_NEXT: if (hit) begin
                    td_next <= mem_rdata[AW-1:0];
                    state   <= S_TD_BUF;
                end
                S_TD_BUF: if (hit) begin
                    buf_ptr <= mem_rdata[AW-1:0];
                    if (remain != '0) begin
                        state <= S_BURST;
                    end else begin
                        if (!last_td) td_ptr <= td_next;
                        else if (!last_cmd) cmd_ptr <= cb_link;
                        state <= after_buf;
                    end
                end
                S_BURST: if (hit) begin
                    buf_ptr <= buf_ptr + AW'(1);
                    remain  <= remain - CNT_ONE;
                    moved   <= moved + CNT_ONE;
                    if (remain == CNT_ONE) begin
                        if (!last_td) td_ptr <= td_next;
                        else if (!last_cmd) cmd_ptr <= cb_link;
                        state <= after_buf;
                    end
                end
                S_STATUS: if (hit) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txdma_engine.sv
// Module: top of the transmit DMA command unit; joins the attention latch to the
// sequencer and exposes the memory master, FIFO write and busy ports.
// Assumes one memory port shared by all fetches, status write and buffer bursts.
module txdma_engine #(
    parameter int             AW       = 16,
    parameter int             DW       = 16,
    parameter logic [AW-1:0]  SCB_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attn,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_data,
    input  logic              fifo_full,
    output logic              busy
);

    logic pend, take;

    txdma_attn_latch u_attn (
        .clk    (clk),
        .rst_n  (rst_n),
        .attn_i (attn),
        .take_i (take),
        .pend_o (pend)
    );

    txdma_seq #(.AW(AW), .DW(DW), .SCB_BASE(SCB_BASE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (pend),
        .take_o    (take),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .fifo_full (fifo_full),
        .busy      (busy)
    );

endmodule

// File: rtl/txdma_checker.sv
// Module: protocol checks on the transmit DMA unit's ports, bound to the top.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module txdma_checker #(
    parameter int             AW       = 16,
    parameter int             DW       = 16,
    parameter logic [AW-1:0]  SCB_BASE = '0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_ack,
    input logic           fifo_wr,
    input logic           fifo_full,
    input logic           busy
);

    // R1: nothing moves while idle.
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !fifo_wr));

    // R7: never push into a full FIFO.
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    // R8: an unacknowledged request is held unless a full FIFO withdraws it.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
        (fifo_full || (mem_req && $stable(mem_addr) && $stable(mem_we))));

    // R9: idle in the cycle after the status write completes.
    a_r9_idle_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !busy);

    // R11: the only write goes to the status word.
    a_r11_write_status_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == SCB_BASE + AW'(2)));

endmodule

bind txdma_engine txdma_checker #(.AW(AW), .DW(DW), .SCB_BASE(SCB_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .fifo_wr   (fifo_wr),
    .fifo_full (fifo_full),
    .busy      (busy)
);

// File: tb/tb_txdma_engine.sv
// Bench: behavioural reference walk of the memory image, compared on every clock.
module tb_txdma_engine;

    localparam int            CLK_PERIOD = 10;
    localparam int            AW = 8;
    localparam int            DW = 16;
    localparam logic [AW-1:0] BASE = 8'h10;
    localparam int            WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic attn = 1'b0;
    logic mem_req, mem_we, mem_ack, fifo_wr, fifo_full, busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, fifo_data;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] exp_st_q[$];
    int checks = 0, errors = 0, st_cnt = 0, cyc = 0;
    bit stall_ack = 0, stall_full = 0;

    assign mem_rdata = mem[mem_addr];

    txdma_engine #(.AW(AW), .DW(DW), .SCB_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .attn(attn),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference: walk the image per the requirements and queue expected results.
    task automatic ref_walk();
        int cp, td, total, guard;
        logic [DW-1:0] hdr, cnt;
        if (!mem[BASE][0]) return;
        cp = mem[BASE + 1] & 8'hFF;
        total = 0;
        guard = 0;
        while (guard < 64) begin
            guard++;
            hdr = mem[cp];
            if (hdr[2:0] == 3'd1) begin
                td = mem[(cp + 2) & 8'hFF] & 8'hFF;
                while (guard < 64) begin
                    guard++;
                    cnt = mem[td];
                    for (int i = 0; i < int'(cnt[14:0]); i++)
                        exp_q.push_back(mem[(mem[(td + 2) & 8'hFF] + i) & 8'hFF]);
                    total += int'(cnt[14:0]);
                    if (cnt[15]) break;
                    td = mem[(td + 1) & 8'hFF] & 8'hFF;
                end
            end
            if (hdr[15]) break;
            cp = mem[(cp + 1) & 8'hFF] & 8'hFF;
        end
        exp_st_q.push_back(16'h8000 | 16'(total));
    endtask

    // Stall pattern driver: inputs change just after each rising edge.
    initial begin
        mem_ack = 1'b1;
        fifo_full = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            mem_ack   = !stall_ack || (cyc % 3 != 0);
            fifo_full = stall_full && (cyc % 7 < 2);
        end
    end

    // Per-clock comparison against the reference queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) chk(!mem_req && !fifo_wr, "R1 idle quiet", {mem_req, fifo_wr}, 0);
            if (fifo_wr) begin
                chk(!fifo_full, "R7 push while full", fifo_full, 0);
                if (exp_q.size() == 0) chk(0, "R5 unexpected push", fifo_data, 0);
                else begin
                    chk(fifo_data == exp_q[0], "R5/R7 push data", fifo_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (mem_req && mem_we && mem_ack) begin
                chk(mem_addr == BASE + 2, "R11 write address", mem_addr, BASE + 2);
                if (exp_st_q.size() == 0) chk(0, "R9 unexpected status", mem_wdata, 0);
                else begin
                    chk(mem_wdata == exp_st_q[0], "R9 status word", mem_wdata, exp_st_q[0]);
                    void'(exp_st_q.pop_front());
                end
                mem[mem_addr] = mem_wdata;
                st_cnt++;
            end
        end
    end

    task automatic pulse(input bit chk_idle);
        @(posedge clk); #1 attn = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (chk_idle) chk(busy == 1'b0, "R2 idle while attn high", busy, 0);
        end
        @(posedge clk); #1 attn = 1'b0;
        repeat (3) @(negedge clk);
        if (chk_idle) chk(busy == 1'b1, "R2 busy after falling edge", busy, 1);
    endtask

    task automatic wait_status(input int target, input string req);
        int t = 0;
        while (st_cnt < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(st_cnt == target, req, st_cnt, target);
        @(negedge clk);
        chk(!busy, {req, " idle after status"}, busy, 0);
        chk(exp_q.size() == 0, {req, " all words pushed"}, exp_q.size(), 0);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // Image A: one transmit command, one descriptor of three words.
    task automatic image_a();
        clear_mem();
        mem[8'h10] = 16'h0001; mem[8'h11] = 16'h0020; mem[8'h12] = 16'h0000;
        mem[8'h20] = 16'h8001; mem[8'h21] = 16'h0000; mem[8'h22] = 16'h0040;
        mem[8'h40] = 16'h8003; mem[8'h41] = 16'h0000; mem[8'h42] = 16'h0080;
        mem[8'h80] = 16'hA001; mem[8'h81] = 16'hA002; mem[8'h82] = 16'hA003;
    endtask

    initial begin
        int snap;
        clear_mem();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !fifo_wr, "R1 reset state", {busy, mem_req, fifo_wr}, 0);

        // R5 R9: single command, single descriptor, no stalls.
        image_a();
        ref_walk();
        pulse(1);
        wait_status(1, "R9 single pass");
        chk(mem[8'h12] == 16'h8003, "R9 status in memory", mem[8'h12], 16'h8003);

        // R4 R6 R7 R8: no-op then transmit over a chain with a zero-count link, with stalls.
        clear_mem();
        mem[8'h10] = 16'h0001; mem[8'h11] = 16'h0020;
        mem[8'h20] = 16'h0002; mem[8'h21] = 16'h0028; mem[8'h22] = 16'h00EE;
        mem[8'h28] = 16'h8001; mem[8'h29] = 16'h0000; mem[8'h2A] = 16'h0040;
        mem[8'h40] = 16'h0002; mem[8'h41] = 16'h0048; mem[8'h42] = 16'h0080;
        mem[8'h48] = 16'h0000; mem[8'h49] = 16'h0050; mem[8'h4A] = 16'h00F0;
        mem[8'h50] = 16'h8004; mem[8'h51] = 16'h0000; mem[8'h52] = 16'h0090;
        mem[8'h80] = 16'hB001; mem[8'h81] = 16'hB002;
        for (int i = 0; i < 4; i++) mem[8'h90 + i] = 16'hC000 + 16'(i);
        mem[8'hEE] = 16'hDEAD; mem[8'hF0] = 16'hBEEF;
        stall_ack = 1; stall_full = 1;
        ref_walk();
        snap = st_cnt;
        pulse(1);
        wait_status(snap + 1, "R4/R6 nop and zero-count chain");
        chk(mem[8'h12] == 16'h8006, "R6 status counts six words", mem[8'h12], 16'h8006);

        // R3: start flag clear, so no fetch beyond word 0 and no write.
        clear_mem();
        mem[8'h10] = 16'h0000; mem[8'h11] = 16'h0020; mem[8'h12] = 16'h1234;
        mem[8'h20] = 16'h8001; mem[8'h22] = 16'h0040;
        mem[8'h40] = 16'h8002; mem[8'h42] = 16'h0080;
        snap = st_cnt;
        pulse(1);
        repeat (20) @(negedge clk);
        chk(st_cnt == snap, "R3 no write when start clear", st_cnt, snap);
        chk(mem[8'h12] == 16'h1234, "R3 status untouched", mem[8'h12], 16'h1234);
        chk(!busy, "R3 back to idle", busy, 0);

        // R10: second attention while busy starts one more pass.
        stall_ack = 1; stall_full = 0;
        image_a();
        ref_walk();
        ref_walk();
        snap = st_cnt;
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(0);
        wait_status(snap + 2, "R10 second pass after busy attention");
        chk(exp_st_q.size() == 0, "R10 all status words seen", exp_st_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule